// File: doc/BRIEF.md
# Trigger-Object Spy and Playback Buffer

This buffer sits on the output of a trigger algorithm that emits up to eight 32-bit trigger objects per bunch crossing. It has two faces. The wide side sees one whole crossing per cycle. The narrow side is a 32-bit register-bus port that reads or writes one stored word at a time.

In spy mode, each valid crossing stores its first five objects into the current crossing slot, and the remaining three are dropped. In playback mode, each valid crossing replaces the algorithm's output with the five objects held in the current slot, and the upper lanes are zeroed. In idle mode the algorithm data passes through and nothing is stored. Sixteen slots are kept.

On the bus side, word index = slot × 5 + object index. Software can therefore preload a sequence of sixteen crossings before playback, or read back a capture after spy mode.

Top module: `tob_spy_buffer`

## Requirements
- R1: After reset, the mode is idle, `cur_slot` is 0 and `bus_rdata` is 0.
- R2: In spy mode, a valid crossing writes lane k (bits 32k+31:32k of `alg_data`) for k = 0..4 into bus word `cur_slot*5+k`. Lanes 5..7 are not stored anywhere.
- R3: In spy or playback mode, each valid crossing advances `cur_slot` by one, and slot 15 wraps to 0.
- R4: In idle mode (`ctrl_mode` 0, and also 3), a valid crossing writes no word and leaves `cur_slot` unchanged.
- R5: In playback mode, `out_data` lane k for k = 0..4 equals bus word `cur_slot*5+k` in the same cycle. Lanes 5..7 are zero, and `out_valid` follows `alg_valid`.
- R6: Outside playback mode, `out_data` equals `alg_data` and `out_valid` equals `alg_valid`.
- R7: A pulse on `ctrl_wr` loads `ctrl_mode` (0 idle, 1 spy, 2 playback) and sets `cur_slot` to 0. A crossing in that same cycle is neither stored nor counted.
- R8: A bus read (`bus_rd` high) returns the addressed word on `bus_rdata` one cycle later. `bus_rdata` holds its value when no read is issued.
- R9: A bus write to an address below 80 stores `bus_wdata`. A write at 80 or above is ignored, and a read at 80 or above returns 0.
- R10: When a bus write and a spy capture hit the same word in one cycle, the capture value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Mode register write strobe |
| ctrl_mode | input | 2 | New mode: 0 idle, 1 spy, 2 playback |
| alg_valid | input | 1 | Algorithm crossing valid |
| alg_data | input | 256 | Eight algorithm objects, lane 0 in the low bits |
| out_valid | output | 1 | Output crossing valid |
| out_data | output | 256 | Objects passed downstream |
| cur_slot | output | 4 | Current crossing slot |
| bus_addr | input | 7 | Bus word index |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rd | input | 1 | Bus read strobe |
| bus_rdata | output | 32 | Bus read data, one cycle after `bus_rd` |

## Verification
The bench builds the block with its default parameters: 32-bit objects, eight lanes, five kept objects and sixteen slots. With these values the bus address space has 80 valid words inside a 7-bit range, so the out-of-range addresses 80 to 127 can be exercised. A full spy pass fills every word and then wraps into slot 0, and a seventeen-crossing playback run crosses the same wrap. Bus-against-capture collisions and mode writes that coincide with a crossing are driven as directed cases.

// File: rtl/tob_spy_buffer.sv
module tob_spy_buffer #(
  parameter int OBJ_W = 32,
  parameter int LANES = 8,
  parameter int KEEP  = 5,
  parameter int SLOTS = 16,
  localparam int WORDS = SLOTS * KEEP,
  localparam int AW    = $clog2(WORDS),
  localparam int SW    = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctrl_wr,
  input  logic [1:0]             ctrl_mode,
  input  logic                   alg_valid,
  input  logic [LANES*OBJ_W-1:0] alg_data,
  output logic                   out_valid,
  output logic [LANES*OBJ_W-1:0] out_data,
  output logic [SW-1:0]          cur_slot,
  input  logic [AW-1:0]          bus_addr,
  input  logic                   bus_wr,
  input  logic [OBJ_W-1:0]       bus_wdata,
  input  logic                   bus_rd,
  output logic [OBJ_W-1:0]       bus_rdata
);

  logic [1:0]       mode;
  logic [SW-1:0]    slot;
  logic [OBJ_W-1:0] mem [WORDS];

  wire spy     = (mode == 2'd1);
  wire play    = (mode == 2'd2);
  wire step    = alg_valid && (spy || play) && !ctrl_wr;
  wire bus_hit = (int'(bus_addr) < WORDS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= 2'd0;
      slot <= '0;
    end else if (ctrl_wr) begin
      mode <= ctrl_mode;
      slot <= '0;
    end else if (step) begin
      slot <= (int'(slot) == SLOTS - 1) ? '0 : slot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (bus_wr && bus_hit)
      mem[bus_addr] <= bus_wdata;
    if (step && spy)
      for (int k = 0; k < KEEP; k++)
        mem[AW'(int'(slot) * KEEP + k)] <= alg_data[k*OBJ_W +: OBJ_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= bus_hit ? mem[bus_addr] : '0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g < KEEP) begin : g_kept
      assign out_data[g*OBJ_W +: OBJ_W] =
        play ? mem[AW'(int'(slot) * KEEP + g)] : alg_data[g*OBJ_W +: OBJ_W];
    end else begin : g_drop
      assign out_data[g*OBJ_W +: OBJ_W] = play ? '0 : alg_data[g*OBJ_W +: OBJ_W];
    end
  end

  assign out_valid = alg_valid;
  assign cur_slot  = slot;

endmodule

// File: rtl/tob_spy_buffer_chk.sv
module tob_spy_buffer_chk #(
  parameter int OBJ_W = 32,
  parameter int LANES = 8,
  parameter int KEEP  = 5,
  parameter int SLOTS = 16,
  parameter int AW    = 7,
  parameter int SW    = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ctrl_wr,
  input logic                   alg_valid,
  input logic [1:0]             mode,
  input logic [SW-1:0]          slot,
  input logic [AW-1:0]          bus_addr,
  input logic                   bus_rd,
  input logic [OBJ_W-1:0]       bus_rdata,
  input logic [LANES*OBJ_W-1:0] out_data
);

  wire active = (mode == 2'd1) || (mode == 2'd2);
  wire adv    = alg_valid && active && !ctrl_wr;

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv && int'(slot) == SLOTS - 1 |=> slot == '0);

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv && int'(slot) != SLOTS - 1 |=> slot == SW'($past(slot) + 1'b1));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr && !active |=> $stable(slot));

  assert_ctrl_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> slot == '0);

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_oob_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && int'(bus_addr) >= SLOTS * KEEP |=> bus_rdata == '0);

  assert_upper_lanes_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 |-> out_data[LANES*OBJ_W-1:KEEP*OBJ_W] == '0);

endmodule

bind tob_spy_buffer tob_spy_buffer_chk #(
  .OBJ_W(OBJ_W), .LANES(LANES), .KEEP(KEEP), .SLOTS(SLOTS), .AW(AW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .alg_valid(alg_valid),
  .mode(mode), .slot(slot), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .out_data(out_data)
);

// File: tb/sim_tob_spy_buffer.sv
module sim_tob_spy_buffer;
  localparam int PERIOD = 10;
  localparam int WORDS  = 80;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         ctrl_wr = 0;
  logic [1:0]   ctrl_mode = 0;
  logic         alg_valid = 0;
  logic [255:0] alg_data = 0;
  logic         out_valid;
  logic [255:0] out_data;
  logic [3:0]   cur_slot;
  logic [6:0]   bus_addr = 0;
  logic         bus_wr = 0;
  logic [31:0]  bus_wdata = 0;
  logic         bus_rd = 0;
  logic [31:0]  bus_rdata;

  logic [31:0]  model [WORDS];
  logic [255:0] seen;
  logic         seen_v;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  tob_spy_buffer u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_mode(ctrl_mode),
    .alg_valid(alg_valid), .alg_data(alg_data), .out_valid(out_valid),
    .out_data(out_data), .cur_slot(cur_slot), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  localparam logic [38:0] VEC [8] = '{
    {7'd0,   32'h1111_0000}, {7'd4,   32'h2222_0004},
    {7'd5,   32'h3333_0005}, {7'd41,  32'h4444_0029},
    {7'd78,  32'h5555_004E}, {7'd79,  32'h6666_004F},
    {7'd80,  32'hDEAD_0050}, {7'd127, 32'hBEEF_007F}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [6:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); ctrl_mode = m; ctrl_wr = 1;
    @(negedge clk); ctrl_wr = 0;
  endtask

  task automatic crossing(input logic [255:0] d);
    @(negedge clk); alg_valid = 1; alg_data = d;
    #1 seen = out_data; seen_v = out_valid;
    @(negedge clk); alg_valid = 0;
  endtask

  function automatic logic [255:0] pattern(input int tag, input int c);
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[k*32 +: 32] = 32'(tag << 24) | 32'(c << 8) | 32'(k);
    return r;
  endfunction

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [255:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
    chk(cur_slot == 0, "R1 slot", 32'(cur_slot), 0);
    alg_data = pattern(9, 9); #1;
    chk(out_data == alg_data, "R1/R6 idle passthrough", out_data[31:0], alg_data[31:0]);

    // R9 table: write all, read all
    for (int i = 0; i < 8; i++) bus_write(VEC[i][38:32], VEC[i][31:0]);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] e;
      e = (VEC[i][38:32] < 7'd80) ? VEC[i][31:0] : 32'd0;
      bus_read(VEC[i][38:32]);
      chk(bus_rdata == e, "R9/R8 table readback", bus_rdata, e);
    end
    bus_read(7'd0);
    @(negedge clk);
    chk(bus_rdata == 32'h1111_0000, "R8 rdata holds", bus_rdata, 32'h1111_0000);

    // R2/R3 spy over 16 crossings
    set_mode(2'd1);
    chk(cur_slot == 0, "R7 slot cleared", 32'(cur_slot), 0);
    for (int c = 0; c < 16; c++) begin
      d = pattern(1, c);
      crossing(d);
      chk(seen == d && seen_v, "R6 spy passthrough", seen[31:0], d[31:0]);
      chk(cur_slot == 4'((c + 1) % 16), "R3 slot advance", 32'(cur_slot), 32'((c + 1) % 16));
      for (int k = 0; k < 5; k++) model[c*5+k] = d[k*32 +: 32];
    end
    for (int w = 0; w < WORDS; w++) begin
      bus_read(7'(w));
      chk(bus_rdata == model[w], "R2 capture layout", bus_rdata, model[w]);
    end
    d = pattern(2, 0);
    crossing(d);
    for (int k = 0; k < 5; k++) model[k] = d[k*32 +: 32];
    bus_read(7'd0);
    chk(bus_rdata == model[0], "R3 wrap overwrite slot 0", bus_rdata, model[0]);
    chk(cur_slot == 1, "R3 slot after wrap", 32'(cur_slot), 1);

    // R4 idle
    set_mode(2'd0);
    crossing(pattern(3, 0));
    chk(cur_slot == 0, "R4 idle slot holds", 32'(cur_slot), 0);
    bus_read(7'd0);
    chk(bus_rdata == model[0], "R4 idle no write", bus_rdata, model[0]);
    set_mode(2'd3);
    crossing(pattern(3, 1));
    chk(cur_slot == 0, "R4 mode 3 idle", 32'(cur_slot), 0);

    // R5 playback over 17 crossings
    set_mode(2'd2);
    for (int c = 0; c < 17; c++) begin
      int s;
      s = c % 16;
      crossing(pattern(4, c));
      for (int k = 0; k < 5; k++)
        chk(seen[k*32 +: 32] == model[s*5+k], "R5 playback lane", seen[k*32 +: 32], model[s*5+k]);
      chk(seen[255:160] == 0, "R5 upper lanes zero", seen[191:160], 0);
      chk(seen_v, "R5 out_valid", 32'(seen_v), 1);
    end
    chk(cur_slot == 1, "R3 playback wrap", 32'(cur_slot), 1);

    // R10 collision: capture wins
    set_mode(2'd1);
    d = pattern(5, 0);
    @(negedge clk);
    alg_valid = 1; alg_data = d; bus_wr = 1; bus_addr = 7'd2; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    alg_valid = 0; bus_wr = 0;
    for (int k = 0; k < 5; k++) model[k] = d[k*32 +: 32];
    bus_read(7'd2);
    chk(bus_rdata == model[2], "R10 capture beats bus", bus_rdata, model[2]);

    // R7 ctrl write with concurrent crossing
    @(negedge clk);
    ctrl_wr = 1; ctrl_mode = 2'd1; alg_valid = 1; alg_data = pattern(6, 0);
    @(negedge clk);
    ctrl_wr = 0; alg_valid = 0;
    chk(cur_slot == 0, "R7 slot zero, crossing not counted", 32'(cur_slot), 0);
    bus_read(7'd0);
    chk(bus_rdata == model[0], "R7 crossing not stored", bus_rdata, model[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule